// File: doc/BRIEF.md
# Codec Register Command Slot Handler

This block lets software reach the control registers of an attached audio codec through a pair of 20-bit command slot words. Software first loads the data slot with the value to be written. It then loads the command slot with a register address and a direction bit. Loading the command slot starts one transaction on a simple request/response codec port.

A write finishes when the codec accepts the request. A read also waits for a response strobe. On that strobe the block fills two receive words. The first is the command echoed back with its direction bit cleared. The second holds the returned 16-bit value, shifted into the upper bits of the slot.

A seven-bit flag vector reports the state of both slots. For the transmit side it shows whether each slot is empty and whether both are empty. For the receive side it shows whether each slot is busy waiting on a read and whether each holds valid data. Reading the second receive word consumes the response.

Top module: `cmd_slot_handler`

## Requirements
- R1: After reset, `slot_flags` is 7'b0000111, both receive words are zero and `cmd_req` is low. Flag bit 0 is command slot empty, bit 1 is data slot empty, bit 2 is both slots empty, bits 3 and 4 are receive busy for command and data slot, and bits 5 and 6 are receive valid for command and data slot.
- R2: A data slot write (`slot2_wr`) stores `wr_word` and clears flag bits 1 and 2 in the following cycle.
- R3: A command slot write while no transaction is outstanding clears flag bits 0 and 2 and raises `cmd_req` in the next cycle. It also presents `cmd_read` = word bit 19, `cmd_addr` = word bits 18:12 and `cmd_wdata` = data slot bits 19:4. If the data slot is written in the same cycle, the new word supplies the data.
- R4: `cmd_req` and the command fields stay unchanged until a cycle with `cmd_ack` high, and `cmd_req` is low in the cycle after that.
- R5: In the cycle after the codec accepts a request, flag bits 0, 1 and 2 are all set, unless the data slot is written in the accepting cycle.
- R6: A command with bit 19 set (read) sets both receive busy flags (bits 3 and 4) together with the command slot write.
- R7: A `rsp_valid` strobe during an outstanding read loads `rx1_word` with the command word with bit 19 cleared and `rx2_word` with `rsp_data` shifted left by 4. It also clears bits 3 and 4 and sets bits 5 and 6. A `rsp_valid` strobe with no read outstanding changes nothing.
- R8: A `rx2_rd` strobe clears both receive valid flags in the next cycle, unless a response arrives in the same cycle, in which case the flags end up set.
- R9: A command slot write while a request waits for acceptance, or while a read waits for its response, is ignored. No new request is issued, the command fields and busy flags are kept, and the later receive echo is that of the original command.
- R10: A write command (bit 19 clear) never sets the busy flags and leaves the block idle after acceptance, ready for the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot1_wr | input | 1 | Write strobe for the command slot |
| slot2_wr | input | 1 | Write strobe for the data slot |
| wr_word | input | 20 | Slot word written by software |
| rx2_rd | input | 1 | Read strobe for the second receive word; consumes the response |
| rx1_word | output | 20 | Received command echo |
| rx2_word | output | 20 | Received data, value in bits 19:4 |
| slot_flags | output | 7 | Slot status flags, encoding in R1 |
| cmd_req | output | 1 | Request to codec, held until accepted |
| cmd_addr | output | 7 | Codec register address |
| cmd_read | output | 1 | 1 for a read request, 0 for a write |
| cmd_wdata | output | 16 | Codec write data |
| cmd_ack | input | 1 | Codec accepts the pending request |
| rsp_valid | input | 1 | Codec read response strobe |
| rsp_data | input | 16 | Codec read response value |

## Verification
The bound checker watches the per-cycle rules on every clock:
- the request stays steady until it is accepted and drops afterwards;
- the transmit empty flags refill after acceptance;
- the two busy flags move as a pair;
- the echo word always has bit 19 clear;
- a response turns busy into valid;
- a receive read clears the valid flags;
- an extra command write during a read in flight leaves the busy state alone.

Only the bench scenarios can show the field extraction for every address and the data padding for many values. They also cover the ignored write leaving the original command in the echo, a same-cycle data write feeding the command, and a stray response while idle leaving the receive words untouched.

// File: rtl/cslot_pkg.sv
package cslot_pkg;
  localparam int FLAG_W   = 7;
  localparam int F_TX1E   = 0;
  localparam int F_TX2E   = 1;
  localparam int F_TX12E  = 2;
  localparam int F_RX1B   = 3;
  localparam int F_RX2B   = 4;
  localparam int F_RX1V   = 5;
  localparam int F_RX2V   = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } cslot_state_e;
endpackage

// File: rtl/cslot_tx_regs.sv
module cslot_tx_regs #(
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_cmd,
  input  logic              ld_data,
  input  logic [SLOT_W-1:0] wr_word,
  input  logic              ack_fire,
  output logic [SLOT_W-1:0] cmd_q,
  output logic [SLOT_W-1:0] data_q,
  output logic              cmd_empty,
  output logic              data_empty,
  output logic              both_empty
);
  logic cmd_empty_n, data_empty_n;

  always_comb begin
    cmd_empty_n  = cmd_empty;
    data_empty_n = data_empty;
    if (ack_fire) begin
      cmd_empty_n  = 1'b1;
      data_empty_n = 1'b1;
    end
    if (ld_cmd)  cmd_empty_n  = 1'b0;
    if (ld_data) data_empty_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= '0;
      data_q     <= '0;
      cmd_empty  <= 1'b1;
      data_empty <= 1'b1;
      both_empty <= 1'b1;
    end else begin
      if (ld_cmd)  cmd_q  <= wr_word;
      if (ld_data) data_q <= wr_word;
      cmd_empty  <= cmd_empty_n;
      data_empty <= data_empty_n;
      both_empty <= cmd_empty_n & data_empty_n;
    end
  end
endmodule

// File: rtl/cslot_issuer.sv
module cslot_issuer
  import cslot_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SLOT_W-1:0] cmd_word,
  input  logic [SLOT_W-1:0] data_word,
  input  logic              cmd_ack,
  input  logic              rsp_valid,
  output logic              cmd_req,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_read,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              idle,
  output logic              ack_fire,
  output logic              rsp_fire,
  output logic              read_start
);
  localparam int RW_BIT   = SLOT_W - 1;
  localparam int ADDR_LSB = SLOT_W - 1 - ADDR_W;
  localparam int DATA_LSB = SLOT_W - DATA_W;

  cslot_state_e state;

  assign idle       = (state == ST_IDLE);
  assign ack_fire   = (state == ST_REQ) & cmd_ack;
  assign rsp_fire   = (state == ST_RSP) & rsp_valid;
  assign read_start = start & idle & cmd_word[RW_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_req   <= 1'b0;
      cmd_addr  <= '0;
      cmd_read  <= 1'b0;
      cmd_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          cmd_req   <= 1'b1;
          cmd_read  <= cmd_word[RW_BIT];
          cmd_addr  <= cmd_word[RW_BIT-1:ADDR_LSB];
          cmd_wdata <= data_word[SLOT_W-1:DATA_LSB];
          state     <= ST_REQ;
        end
        ST_REQ: if (cmd_ack) begin
          cmd_req <= 1'b0;
          state   <= cmd_read ? ST_RSP : ST_IDLE;
        end
        ST_RSP: if (rsp_valid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cslot_rx_capture.sv
module cslot_rx_capture #(
  parameter int SLOT_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              read_start,
  input  logic              rsp_fire,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [SLOT_W-1:0] echo_word,
  input  logic              rd_clr,
  output logic [SLOT_W-1:0] rx1_word,
  output logic [SLOT_W-1:0] rx2_word,
  output logic [1:0]        busy,
  output logic [1:0]        valid
);
  localparam int PAD_W = SLOT_W - DATA_W;
  localparam logic [SLOT_W-1:0] RW_MASK = {1'b0, {(SLOT_W-1){1'b1}}};

  for (genvar s = 0; s < 2; s++) begin : g_slot_flags
    always_ff @(posedge clk) begin
      if (rst) begin
        busy[s]  <= 1'b0;
        valid[s] <= 1'b0;
      end else begin
        if (read_start)    busy[s] <= 1'b1;
        else if (rsp_fire) busy[s] <= 1'b0;
        if (rsp_fire)      valid[s] <= 1'b1;
        else if (rd_clr)   valid[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx1_word <= '0;
      rx2_word <= '0;
    end else if (rsp_fire) begin
      rx1_word <= echo_word & RW_MASK;
      rx2_word <= {rsp_data, {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/cmd_slot_handler.sv
module cmd_slot_handler
  import cslot_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot1_wr,
  input  logic              slot2_wr,
  input  logic [SLOT_W-1:0] wr_word,
  input  logic              rx2_rd,
  output logic [SLOT_W-1:0] rx1_word,
  output logic [SLOT_W-1:0] rx2_word,
  output logic [FLAG_W-1:0] slot_flags,
  output logic              cmd_req,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_read,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_ack,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data
);
  logic              idle, ack_fire, rsp_fire, read_start, cmd_accept;
  logic [SLOT_W-1:0] cmd_q, data_q, data_src;
  logic              tx1_e, tx2_e, tx12_e;
  logic [1:0]        rx_busy, rx_valid;

  assign cmd_accept = slot1_wr & idle;
  assign data_src   = slot2_wr ? wr_word : data_q;

  cslot_tx_regs #(.SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst(rst),
    .ld_cmd(cmd_accept), .ld_data(slot2_wr), .wr_word(wr_word),
    .ack_fire(ack_fire),
    .cmd_q(cmd_q), .data_q(data_q),
    .cmd_empty(tx1_e), .data_empty(tx2_e), .both_empty(tx12_e)
  );

  cslot_issuer #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_iss (
    .clk(clk), .rst(rst),
    .start(cmd_accept), .cmd_word(wr_word), .data_word(data_src),
    .cmd_ack(cmd_ack), .rsp_valid(rsp_valid),
    .cmd_req(cmd_req), .cmd_addr(cmd_addr), .cmd_read(cmd_read),
    .cmd_wdata(cmd_wdata), .idle(idle), .ack_fire(ack_fire),
    .rsp_fire(rsp_fire), .read_start(read_start)
  );

  cslot_rx_capture #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst),
    .read_start(read_start), .rsp_fire(rsp_fire), .rsp_data(rsp_data),
    .echo_word(cmd_q), .rd_clr(rx2_rd),
    .rx1_word(rx1_word), .rx2_word(rx2_word),
    .busy(rx_busy), .valid(rx_valid)
  );

  always_comb begin
    slot_flags          = '0;
    slot_flags[F_TX1E]  = tx1_e;
    slot_flags[F_TX2E]  = tx2_e;
    slot_flags[F_TX12E] = tx12_e;
    slot_flags[F_RX1B]  = rx_busy[0];
    slot_flags[F_RX2B]  = rx_busy[1];
    slot_flags[F_RX1V]  = rx_valid[0];
    slot_flags[F_RX2V]  = rx_valid[1];
  end
endmodule

// File: rtl/cslot_checker.sv
module cslot_checker #(
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              slot1_wr,
  input logic              slot2_wr,
  input logic              rx2_rd,
  input logic [SLOT_W-1:0] rx1_word,
  input logic [6:0]        slot_flags,
  input logic              cmd_req,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_read,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              cmd_ack,
  input logic              rsp_valid
);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_addr) && $stable(cmd_read) && $stable(cmd_wdata));

  p_req_drop_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_req && cmd_ack |=> !cmd_req);

  p_tx_refill_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_req && cmd_ack && !slot2_wr |=> slot_flags[2:0] == 3'b111);

  p_busy_pair_r6: assert property (@(posedge clk) disable iff (rst)
    slot_flags[3] == slot_flags[4]);

  p_rsp_valid_r7: assert property (@(posedge clk) disable iff (rst)
    slot_flags[3] && !cmd_req && rsp_valid |=> slot_flags[6:3] == 4'b1100);

  p_echo_rw_clear_r7: assert property (@(posedge clk) disable iff (rst)
    !rx1_word[SLOT_W-1]);

  p_valid_clear_r8: assert property (@(posedge clk) disable iff (rst)
    rx2_rd && !rsp_valid |=> slot_flags[6:5] == 2'b00);

  p_ignore_cmd_r9: assert property (@(posedge clk) disable iff (rst)
    slot_flags[3] && !cmd_req && slot1_wr && !rsp_valid |=> slot_flags[3] && !cmd_req);
endmodule

bind cmd_slot_handler cslot_checker #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cslot_checker (
  .clk(clk), .rst(rst), .slot1_wr(slot1_wr), .slot2_wr(slot2_wr), .rx2_rd(rx2_rd),
  .rx1_word(rx1_word), .slot_flags(slot_flags), .cmd_req(cmd_req),
  .cmd_addr(cmd_addr), .cmd_read(cmd_read), .cmd_wdata(cmd_wdata),
  .cmd_ack(cmd_ack), .rsp_valid(rsp_valid)
);

// File: tb/test_cmd_slot_handler.sv
module test_cmd_slot_handler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slot1_wr = 0, slot2_wr = 0, rx2_rd = 0;
  logic [19:0] wr_word = '0;
  logic [19:0] rx1_word, rx2_word;
  logic [6:0]  slot_flags;
  logic        cmd_req, cmd_read;
  logic [6:0]  cmd_addr;
  logic [15:0] cmd_wdata;
  logic        cmd_ack = 0, rsp_valid = 0;
  logic [15:0] rsp_data = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [19:0] exp_tx2 = '0;

  always #2 clk = ~clk;

  cmd_slot_handler i_cmd_slot_handler (
    .clk(clk), .rst(rst), .slot1_wr(slot1_wr), .slot2_wr(slot2_wr),
    .wr_word(wr_word), .rx2_rd(rx2_rd), .rx1_word(rx1_word), .rx2_word(rx2_word),
    .slot_flags(slot_flags), .cmd_req(cmd_req), .cmd_addr(cmd_addr),
    .cmd_read(cmd_read), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr_data(input logic [19:0] w);
    @(negedge clk); slot2_wr = 1; wr_word = w;
    @(negedge clk); slot2_wr = 0;
    exp_tx2 = w;
  endtask

  task automatic wr_cmd(input logic [19:0] w);
    @(negedge clk); slot1_wr = 1; wr_word = w;
    @(negedge clk); slot1_wr = 0;
  endtask

  task automatic accept(input int dly);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R4 req held", {31'd0, cmd_req}, 32'd1);
    end
    cmd_ack = 1;
    @(negedge clk); cmd_ack = 0;
    chk("R4 req dropped", {31'd0, cmd_req}, 32'd0);
    chk("R5 tx empties", {29'd0, slot_flags[2:0]}, 32'h7);
  endtask

  task automatic respond(input logic [15:0] d, input int dly);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R6 busy while waiting", {30'd0, slot_flags[4:3]}, 32'h3);
    end
    rsp_valid = 1; rsp_data = d;
    @(negedge clk); rsp_valid = 0;
  endtask

  task automatic do_cmd(input logic [19:0] w, input int adly, input int rdly, input logic [15:0] d);
    wr_cmd(w);
    chk("R3 req raised", {31'd0, cmd_req}, 32'd1);
    chk("R3 tx1/tx12 cleared", {30'd0, slot_flags[2], slot_flags[0]}, 32'd0);
    chk("R3 addr", {25'd0, cmd_addr}, {25'd0, w[18:12]});
    chk("R3 read bit", {31'd0, cmd_read}, {31'd0, w[19]});
    chk("R3 wdata", {16'd0, cmd_wdata}, {16'd0, exp_tx2[19:4]});
    chk(w[19] ? "R6 busy set" : "R10 no busy", {30'd0, slot_flags[4:3]}, w[19] ? 32'h3 : 32'h0);
    accept(adly);
    if (w[19]) begin
      respond(d, rdly);
      chk("R7 rx1 echo", {12'd0, rx1_word}, {12'd0, 1'b0, w[18:0]});
      chk("R7 rx2 data", {12'd0, rx2_word}, {12'd0, d, 4'h0});
      chk("R7 flags", {28'd0, slot_flags[6:3]}, 32'hC);
      @(negedge clk); rx2_rd = 1;
      @(negedge clk); rx2_rd = 0;
      chk("R8 valid cleared", {30'd0, slot_flags[6:5]}, 32'd0);
    end else begin
      chk("R10 idle after write", {28'd0, slot_flags[6:3]}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 flags", {25'd0, slot_flags}, 32'h07);
    chk("R1 rx1", {12'd0, rx1_word}, 32'd0);
    chk("R1 rx2", {12'd0, rx2_word}, 32'd0);
    chk("R1 req", {31'd0, cmd_req}, 32'd0);

    wr_data(20'h12345);
    chk("R2 data flags", {29'd0, slot_flags[2:0]}, 32'h1);

    // sweep every address with a write then a read
    for (int a = 0; a < 128; a++) begin
      logic [15:0] d;
      d = 16'(a * 16'h0135 + 16'h002a);
      wr_data({d, 4'(a)});
      chk("R2 data empty clr", {31'd0, slot_flags[1]}, 32'd0);
      do_cmd({1'b0, 7'(a), 12'(a * 3)}, a % 3, 0, 16'd0);
      do_cmd({1'b1, 7'(a), 12'habc}, a % 2, a % 4, ~d);
    end

    // same-cycle command and data write
    @(negedge clk); slot1_wr = 1; slot2_wr = 1; wr_word = 20'h3c5a6;
    @(negedge clk); slot1_wr = 0; slot2_wr = 0; exp_tx2 = 20'h3c5a6;
    chk("R3 same-cycle wdata", {16'd0, cmd_wdata}, 32'h3c5a);
    chk("R3 same-cycle addr", {25'd0, cmd_addr}, {25'd0, 7'h3c});
    accept(1);

    // ignored command write while a request is pending
    wr_cmd(20'h15000);
    wr_cmd(20'h97fff);
    chk("R9 addr kept", {25'd0, cmd_addr}, 32'h15);
    chk("R9 read kept", {31'd0, cmd_read}, 32'd0);
    accept(0);
    chk("R9 no new req", {31'd0, cmd_req}, 32'd0);

    // ignored command write while a read awaits response
    wr_cmd(20'hA2111);
    accept(0);
    wr_cmd(20'h8f222);
    chk("R9 no req during rsp wait", {31'd0, cmd_req}, 32'd0);
    chk("R9 busy kept", {30'd0, slot_flags[4:3]}, 32'h3);
    respond(16'hbeef, 1);
    chk("R9 original echo", {12'd0, rx1_word}, 32'h22111);
    chk("R7 rx2 after ignore", {12'd0, rx2_word}, 32'hbeef0);
    @(negedge clk); rx2_rd = 1;
    @(negedge clk); rx2_rd = 0;

    // stray response while idle
    rsp_valid = 1; rsp_data = 16'h1234;
    @(negedge clk); rsp_valid = 0;
    chk("R7 stray rsp rx2", {12'd0, rx2_word}, 32'hbeef0);
    chk("R7 stray rsp flags", {28'd0, slot_flags[6:3]}, 32'd0);

    // response and receive read in the same cycle
    wr_cmd(20'h81000);
    accept(0);
    @(negedge clk); rsp_valid = 1; rsp_data = 16'h0f0f; rx2_rd = 1;
    @(negedge clk); rsp_valid = 0; rx2_rd = 0;
    chk("R8 response wins", {30'd0, slot_flags[6:5]}, 32'h3);
    chk("R7 rx2 value", {12'd0, rx2_word}, 32'h0f0f0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule